// File: doc/BRIEF.md
# Conversion Start Generator

This block decides when a data-conversion sequence begins. One source is a software start strobe, a single-cycle pulse raised by a control-register write. The other sources are a bank of asynchronous event lines. A select field picks one of them, and a mode field decides how the hardware side behaves. Hardware triggering can be switched off, driven by edges on the selected line, run as a free-running continuous restart, or paced by an internal interval counter.

Every accepted request produces a one-clock start pulse for the sequencer. The block then counts itself busy until the sequencer reports completion. A request that arrives while busy is discarded and sets a sticky overrun flag, which software clears. A completion and a new request in the same cycle count as back-to-back: the request is taken. Triggers are meant to be spaced further apart than the longest sequence, and the overrun flag shows when that rule was broken.

Top module: `conv_start_ctrl`

## Requirements
- R1: A one-cycle `sw_start_i` pulse sampled at clock edge n while idle makes `start_o` high for the cycle after edge n, in every mode.
- R2: With `mode_i` = 0 (hardware off), activity on `trig_i` never produces `start_o`.
- R3: With `mode_i` = 1 (edge), `edge_cfg_i` chooses the active edge: 1 = rising, 2 = falling, 3 = both, 0 = none. A qualifying change of the selected line, first sampled at edge n, raises `start_o` after edge n+2.
- R4: `trig_sel_i` picks the line with that index; edges on the other lines have no effect.
- R5: With `mode_i` = 2 (continuous), a start is issued at the first edge where the block is idle, and again at every edge where `seq_done_i` is high.
- R6: With `mode_i` = 3 (periodic) and `period_i` = P ≥ 1, the first start comes P+1 edges after the mode or period value is applied, and further starts follow every P edges. A change of mode or period restarts the count. P = 0 gives no starts.
- R7: `start_o` is high for exactly one cycle per accepted request.
- R8: `busy_o` rises together with `start_o` and falls at the edge that samples `seq_done_i` high. A request seen while busy without `seq_done_i` is dropped.
- R9: A dropped request sets `overrun_o`, which stays high until `ovr_clr_i` is sampled high. If a drop and a clear fall in the same cycle, the drop wins.
- R10: A request sampled in the same cycle as `seq_done_i` is accepted, and `busy_o` stays high.
- R11: After reset, `start_o`, `busy_o` and `overrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_start_i | input | 1 | Software start strobe |
| trig_i | input | NUM_TRIG | Asynchronous event lines |
| trig_sel_i | input | SEL_W | Index of the event line used |
| mode_i | input | 2 | 0 off, 1 edge, 2 continuous, 3 periodic |
| edge_cfg_i | input | 2 | 0 none, 1 rising, 2 falling, 3 both |
| period_i | input | PER_W | Interval in clocks for periodic mode |
| seq_done_i | input | 1 | Sequence completion strobe |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| start_o | output | 1 | One-cycle start pulse |
| busy_o | output | 1 | Sequence in progress |
| overrun_o | output | 1 | Sticky dropped-request flag |

## Verification
A new start request and the completion strobe can land in the same cycle. The bench provokes this by raising `sw_start_i` together with `seq_done_i`, and by feeding completions in continuous mode. A correct design issues the start one cycle later with `busy_o` held high. A second overlap sets a drop against an overrun clear, and the flag must stay set. A scoreboard holds the start cycle computed for each stimulus and compares it with the cycle in which `start_o` actually appears.

// File: rtl/conv_start_pkg.sv
package conv_start_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_EDGE   = 2'd1,
    MODE_CONT   = 2'd2,
    MODE_PERIOD = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_cfg_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
  import conv_start_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      level_i,
  input  edge_cfg_e cfg_i,
  output logic      evt_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  always_comb begin
    unique case (cfg_i)
      EDGE_RISE: evt_o = rise;
      EDGE_FALL: evt_o = fall;
      EDGE_BOTH: evt_o = rise | fall;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  logic [PER_W-1:0] cnt_q, per_q;
  logic             en_q;
  logic             cfg_chg, per_zero, reload;

  assign cfg_chg  = (en_i != en_q) || (period_i != per_q);
  assign per_zero = (period_i == '0);
  assign tick_o   = en_i && !cfg_chg && !per_zero && (cnt_q == '0);
  assign reload   = !en_i || cfg_chg || per_zero || (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q  <= en_i;
      per_q <= period_i;
      // count restarts from the new value on any config change
      if (reload) cnt_q <= period_i - 1'b1;
      else        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/conv_start_ctrl.sv
module conv_start_ctrl
  import conv_start_pkg::*;
#(
  parameter int unsigned NUM_TRIG    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PER_W       = 16,
  localparam int unsigned SEL_W      = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_start_i,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]    trig_sel_i,
  input  logic [1:0]          mode_i,
  input  logic [1:0]          edge_cfg_i,
  input  logic [PER_W-1:0]    period_i,
  input  logic                seq_done_i,
  input  logic                ovr_clr_i,
  output logic                start_o,
  output logic                busy_o,
  output logic                overrun_o
);
  trig_mode_e        mode;
  logic [NUM_TRIG-1:0] trig_sync_w;
  logic              sel_lvl, edge_evt, per_tick;
  logic              free, hw_req, req_any, accept, drop;
  logic              start_q, busy_q, ovr_q;

  assign mode = trig_mode_e'(mode_i);

  trig_sync #(.WIDTH(NUM_TRIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(trig_i),
    .sync_o (trig_sync_w)
  );

  assign sel_lvl = (32'(trig_sel_i) < NUM_TRIG) ? trig_sync_w[trig_sel_i] : 1'b0;

  trig_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(sel_lvl),
    .cfg_i  (edge_cfg_e'(edge_cfg_i)),
    .evt_o  (edge_evt)
  );

  period_timer #(.PER_W(PER_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mode == MODE_PERIOD),
    .period_i(period_i),
    .tick_o  (per_tick)
  );

  // completion in this cycle frees the slot for a back-to-back start
  assign free = !busy_q || seq_done_i;

  always_comb begin
    unique case (mode)
      MODE_EDGE:   hw_req = edge_evt;
      MODE_CONT:   hw_req = free;
      MODE_PERIOD: hw_req = per_tick;
      default:     hw_req = 1'b0;
    endcase
  end

  assign req_any = sw_start_i || hw_req;
  assign accept  = req_any && free;
  assign drop    = req_any && !free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept)          busy_q <= 1'b1;
      else if (seq_done_i) busy_q <= 1'b0;
      if (drop)           ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign start_o   = start_q;
  assign busy_o    = busy_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/conv_start_ctrl_chk.sv
module conv_start_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sw_start_i,
  input logic [1:0] mode_i,
  input logic       seq_done_i,
  input logic       ovr_clr_i,
  input logic       start_o,
  input logic       busy_o,
  input logic       overrun_o
);
  p_mode_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !sw_start_i) |=> !start_o);

  p_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);

  p_busy_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !seq_done_i) |=> busy_o);

  p_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !seq_done_i && sw_start_i) |=> (!start_o && overrun_o));

  p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);

  p_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && seq_done_i && sw_start_i) |=> (start_o && busy_o));

  p_idle_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && sw_start_i) |=> start_o);
endmodule

bind conv_start_ctrl conv_start_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sw_start_i(sw_start_i),
  .mode_i    (mode_i),
  .seq_done_i(seq_done_i),
  .ovr_clr_i (ovr_clr_i),
  .start_o   (start_o),
  .busy_o    (busy_o),
  .overrun_o (overrun_o)
);

// File: tb/conv_start_ctrl_test.sv
module conv_start_ctrl_test;
  localparam int unsigned NT = 4;
  localparam int unsigned SW = 2;
  localparam int unsigned PW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sw_start_i = 1'b0;
  logic [NT-1:0] trig_i = '0;
  logic [SW-1:0] trig_sel_i = '0;
  logic [1:0]    mode_i = 2'd0;
  logic [1:0]    edge_cfg_i = 2'd1;
  logic [PW-1:0] period_i = '0;
  logic          seq_done_i = 1'b0;
  logic          ovr_clr_i = 1'b0;
  logic          start_o, busy_o, overrun_o;

  typedef struct {int cyc; string req;} exp_t;
  exp_t  exp_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  string cur_req = "R11";
  bit    done_flag = 1'b0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  conv_start_ctrl #(.NUM_TRIG(NT), .SYNC_STAGES(2), .PER_W(PW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sw_start_i(sw_start_i), .trig_i(trig_i),
    .trig_sel_i(trig_sel_i), .mode_i(mode_i), .edge_cfg_i(edge_cfg_i),
    .period_i(period_i), .seq_done_i(seq_done_i), .ovr_clr_i(ovr_clr_i),
    .start_o(start_o), .busy_o(busy_o), .overrun_o(overrun_o)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic expect_start(int at, string req);
    exp_t e;
    e.cyc = at;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk_i);
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic do_done();
    seq_done_i = 1'b1;
    step();
    seq_done_i = 1'b0;
  endtask

  // monitor: every start pulse must match the next expected cycle (R7)
  always @(negedge clk_i) begin
    if (rst_ni && start_o) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL %s: start_o at cycle %0d, expected none", cur_req, cyc);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.cyc == cyc, e.req, cyc, e.cyc);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // edge-mode helper: change a line at cycle c, optionally expect start at c+3
  task automatic edge_case(int idx, bit val, bit fire, string req);
    int c;
    cur_req = req;
    c = cyc;
    trig_i[idx] = val;
    if (fire) expect_start(c + 3, req);
    wait_to(c + 5);
    if (fire) do_done();
    wait_to(cyc + 2);
  endtask

  initial begin
    int c;
    // R11 reset state
    repeat (3) step();
    chk(start_o == 1'b0, "R11", start_o, 0);
    chk(busy_o == 1'b0, "R11", busy_o, 0);
    chk(overrun_o == 1'b0, "R11", overrun_o, 0);
    rst_ni = 1'b1;
    repeat (2) step();

    // R1 software start
    cur_req = "R1";
    c = cyc;
    sw_start_i = 1'b1;
    expect_start(c + 1, "R1");
    step();
    sw_start_i = 1'b0;
    step();
    chk(busy_o == 1'b1, "R8", busy_o, 1);
    do_done();
    chk(busy_o == 1'b0, "R8", busy_o, 0);

    // R2 hardware off: trigger edges ignored
    edge_case(0, 1'b1, 1'b0, "R2");
    edge_case(0, 1'b0, 1'b0, "R2");
    chk(busy_o == 1'b0, "R2", busy_o, 0);

    // R3 edge selection
    mode_i = 2'd1;
    edge_cfg_i = 2'd1;
    step();
    edge_case(0, 1'b1, 1'b1, "R3");
    edge_case(0, 1'b0, 1'b0, "R3");
    edge_cfg_i = 2'd2;
    edge_case(0, 1'b1, 1'b0, "R3");
    edge_case(0, 1'b0, 1'b1, "R3");
    edge_cfg_i = 2'd3;
    edge_case(0, 1'b1, 1'b1, "R3");
    edge_case(0, 1'b0, 1'b1, "R3");
    edge_cfg_i = 2'd0;
    edge_case(0, 1'b1, 1'b0, "R3");
    edge_case(0, 1'b0, 1'b0, "R3");

    // R4 line select
    edge_cfg_i = 2'd1;
    trig_sel_i = 2'd2;
    step();
    edge_case(0, 1'b1, 1'b0, "R4");
    edge_case(2, 1'b1, 1'b1, "R4");
    edge_case(0, 1'b0, 1'b0, "R4");
    edge_case(2, 1'b0, 1'b0, "R4");
    trig_sel_i = 2'd0;
    mode_i = 2'd0;
    step();

    // R9 overrun on a dropped request, sticky, drop beats clear
    cur_req = "R9";
    c = cyc;
    sw_start_i = 1'b1;
    expect_start(c + 1, "R9");
    step();
    step();
    sw_start_i = 1'b0;
    chk(overrun_o == 1'b1, "R9", overrun_o, 1);
    chk(busy_o == 1'b1, "R8", busy_o, 1);
    sw_start_i = 1'b1;
    ovr_clr_i = 1'b1;
    step();
    sw_start_i = 1'b0;
    chk(overrun_o == 1'b1, "R9", overrun_o, 1);
    step();
    ovr_clr_i = 1'b0;
    chk(overrun_o == 1'b0, "R9", overrun_o, 0);

    // R10 request together with completion
    cur_req = "R10";
    c = cyc;
    sw_start_i = 1'b1;
    seq_done_i = 1'b1;
    expect_start(c + 1, "R10");
    step();
    sw_start_i = 1'b0;
    seq_done_i = 1'b0;
    chk(busy_o == 1'b1, "R10", busy_o, 1);
    chk(overrun_o == 1'b0, "R10", overrun_o, 0);
    do_done();
    chk(busy_o == 1'b0, "R8", busy_o, 0);

    // R5 continuous restart
    cur_req = "R5";
    c = cyc;
    mode_i = 2'd2;
    expect_start(c + 1, "R5");
    wait_to(c + 3);
    expect_start(c + 4, "R5");
    do_done();
    wait_to(c + 6);
    mode_i = 2'd0;
    do_done();
    step();
    chk(busy_o == 1'b0, "R5", busy_o, 0);

    // R6 periodic timer with restart on period change
    cur_req = "R6";
    c = cyc;
    period_i = 16'd5;
    mode_i = 2'd3;
    expect_start(c + 6, "R6");
    expect_start(c + 11, "R6");
    wait_to(c + 8);
    do_done();
    wait_to(c + 13);
    do_done();
    period_i = 16'd3;
    expect_start(c + 18, "R6");
    wait_to(c + 18);
    mode_i = 2'd0;
    do_done();
    chk(overrun_o == 1'b0, "R6", overrun_o, 0);

    // R6 zero period gives no starts
    period_i = 16'd0;
    mode_i = 2'd3;
    repeat (12) step();
    mode_i = 2'd0;
    step();

    cur_req = "R7";
    repeat (4) step();
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    finish_run();
  end
endmodule